// File: doc/BRIEF.md
# Peripheral Port Hub

This block gathers the simple peripherals of a small computer behind one set of eight byte-wide ports. It takes the fast oscillator clock and turns it into a system clock enable that fires on one cycle in every four. It keeps a free-running tick counter and receives bytes from a PS/2 keyboard. It also holds a general output byte for the LEDs and speaker, and two direct LCD line registers. A status byte shows at a glance which devices are ready, together with the raw levels of the navigation switches. The serial receiver and transmitter are outside the block; only their ready and idle flags come in here.

The CPU uses a select strobe, a read strobe, a write strobe and a 3-bit port index. Read data is combinational while select and read are both high. Register writes and the side effect of a keyboard read take place on the clock edge where the system clock enable is high. The CPU holds its strobes for one full system clock period, so exactly one such edge falls inside each access. The keyboard clock and data pins are inputs only.

Top module: `periph_hub`

## Requirements
- R1: `sys_ce` is high on exactly one cycle in every CLK_DIV (4) input clocks. Counting clock edges after reset release as 1, 2, 3 and so on, it is high after edge e when e mod 4 equals 3.
- R2: The tick counter, read at port 2, advances by one on every TICK_DIV (16)th system clock enable and wraps from 255 to 0. After e edges it reads (e / 64) mod 256.
- R3: A keyboard frame is a 0 start bit, eight data bits least significant first, an odd parity bit and a 1 stop bit. Each bit is taken on a falling keyboard clock after two-flop synchronisation. A good frame loads the byte (read at port 0) and sets the keyboard ready flag.
- R4: A frame with wrong parity or a stop bit of 0 is discarded: the ready flag stays clear and port 0 keeps the previous byte.
- R5: There is no buffering. A second good frame that arrives before the CPU reads overwrites the first byte.
- R6: A read of port 0 clears the keyboard ready flag. If a new byte completes on the same edge, the flag stays set.
- R7: Port 1 reads the status byte: bit 0 keyboard ready, bit 1 serial receive ready, bit 2 serial transmit idle, bit 3 up switch, bit 4 down switch, bit 5 set switch, and bits 7:6 zero.
- R8: A write to port 3 loads the general output byte, which drives `gp_out` and reads back at port 3. No other write changes it.
- R9: A write to port 4 loads `lcd_data`. A write to port 5 loads the low LCDC_W (3) bits into `lcd_ctrl`. Both read back at their ports, with port 5 zero-extended.
- R10: Ports 6 and 7 read as 0 and writes to them change no output. `bus_rdata` is 0 whenever select or read is low.
- R11: After reset the tick, the output byte, both LCD registers, the keyboard byte and the ready flag are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock (20 MHz) |
| rst_n | input | 1 | Synchronous active-low reset |
| sys_ce | output | 1 | System clock enable, one cycle in CLK_DIV |
| bus_sel | input | 1 | Port select strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_port | input | 3 | Port index |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, 0 when not reading |
| kbd_clk | input | 1 | PS/2 keyboard clock line |
| kbd_dat | input | 1 | PS/2 keyboard data line |
| sio_rx_ready | input | 1 | External serial receiver has a byte |
| sio_tx_idle | input | 1 | External serial transmitter is idle |
| nav_up | input | 1 | Up switch level |
| nav_down | input | 1 | Down switch level |
| nav_set | input | 1 | Set switch level |
| gp_out | output | 8 | General output byte (LEDs, speaker) |
| lcd_data | output | 8 | LCD data lines |
| lcd_ctrl | output | 3 | LCD control lines |

## Verification
The assertions check several rules on every cycle. The enable never stays high for two cycles in a row. The tick only steps by one, and only after an enable. Register writes land with the written value, and the output byte holds when it is not written. The ready flag rises after every accepted byte and falls after a plain data read. The receiver's bit counter never runs past the parity position. What the assertions cannot show is the meaning of the data. The bench's scenarios cover the exact byte rebuilt from serial frames, the rejection of bad parity and stop bits, overwrite without buffering, the status bit layout across all switch and flag combinations, and the full 256-step wrap of the tick at its exact edge count.

// File: rtl/hub_pkg.sv
package hub_pkg;
   typedef enum logic [2:0] {
      PORT_KBD   = 3'd0,
      PORT_STAT  = 3'd1,
      PORT_TICK  = 3'd2,
      PORT_GPO   = 3'd3,
      PORT_LCDD  = 3'd4,
      PORT_LCDC  = 3'd5,
      PORT_RSV6  = 3'd6,
      PORT_RSV7  = 3'd7
   } port_e;

   localparam int STAT_KB  = 0;
   localparam int STAT_RX  = 1;
   localparam int STAT_TX  = 2;
   localparam int STAT_UP  = 3;
   localparam int STAT_DN  = 4;
   localparam int STAT_SET = 5;
   localparam int STAT_USED = 6;
endpackage

// File: rtl/hub_timebase.sv
module hub_timebase #(
   parameter int CLK_DIV  = 4,
   parameter int TICK_DIV = 16,
   parameter int TICK_W   = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic              ce,
   output logic [TICK_W-1:0] tick
);
   localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

   initial begin
      assert (CLK_DIV >= 1) else $error("CLK_DIV must be at least 1");
      assert (TICK_DIV >= 2) else $error("TICK_DIV must be at least 2");
      assert (TICK_W >= 1) else $error("TICK_W must be at least 1");
   end

   generate
      if (CLK_DIV == 1) begin : g_nodiv
         assign ce = 1'b1;
      end else begin : g_div
         localparam int DIV_W = $clog2(CLK_DIV);
         logic [DIV_W-1:0] cnt;
         always_ff @(posedge clk) begin
            if (!rst_n)                          cnt <= '0;
            else if (cnt == DIV_W'(CLK_DIV - 1)) cnt <= '0;
            else                                 cnt <= cnt + DIV_W'(1);
         end
         assign ce = (cnt == DIV_W'(CLK_DIV - 1));

         // R1
         ce_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ce |=> !ce);
      end
   endgenerate

   logic [PRE_W-1:0] pre;
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pre  <= '0;
         tick <= '0;
      end else if (ce) begin
         if (pre == PRE_W'(TICK_DIV - 1)) begin
            pre  <= '0;
            tick <= tick + TICK_W'(1);
         end else begin
            pre <= pre + PRE_W'(1);
         end
      end
   end

   // R2
   tick_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(tick) |-> (tick == $past(tick) + TICK_W'(1)) && $past(ce));
endmodule

// File: rtl/hub_ps2rx.sv
module hub_ps2rx #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ps2_clk,
   input  logic          ps2_dat,
   output logic          byte_vld,
   output logic [DW-1:0] byte_out
);
   localparam int CNT_W = $clog2(DW + 3);
   localparam logic [CNT_W-1:0] LAST_SHIFT = CNT_W'(DW + 1);

   logic [2:0]     csync;
   logic [1:0]     dsync;
   logic           fall;
   logic           bit_in;
   logic [CNT_W-1:0] cnt;
   logic [DW:0]    shreg;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         csync <= 3'b111;
         dsync <= 2'b11;
      end else begin
         csync <= {csync[1:0], ps2_clk};
         dsync <= {dsync[0], ps2_dat};
      end
   end

   assign fall   = csync[2] & ~csync[1];
   assign bit_in = dsync[1];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt      <= '0;
         shreg    <= '0;
         byte_vld <= 1'b0;
         byte_out <= '0;
      end else begin
         byte_vld <= 1'b0;
         if (fall) begin
            if (cnt == '0) begin
               if (!bit_in) cnt <= CNT_W'(1);
            end else if (cnt <= LAST_SHIFT) begin
               shreg <= {bit_in, shreg[DW:1]};
               cnt   <= cnt + CNT_W'(1);
            end else begin
               cnt <= '0;
               if (bit_in && (^shreg)) begin
                  byte_vld <= 1'b1;
                  byte_out <= shreg[DW-1:0];
               end
            end
         end
      end
   end

   // R3
   vld_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      byte_vld |-> $past(fall));

   // R4
   cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CNT_W'(DW + 2));
endmodule

// File: rtl/hub_portregs.sv
module hub_portregs
   import hub_pkg::*;
#(
   parameter int DW     = 8,
   parameter int TICK_W = 8,
   parameter int LCDC_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce,
   input  logic              sel,
   input  logic              rd,
   input  logic              wr,
   input  logic [2:0]        port,
   input  logic [DW-1:0]     wdata,
   input  logic              kb_vld,
   input  logic [DW-1:0]     kb_byte,
   input  logic [TICK_W-1:0] tick,
   input  logic              rx_rdy,
   input  logic              tx_idle,
   input  logic              sw_up,
   input  logic              sw_dn,
   input  logic              sw_set,
   output logic [DW-1:0]     rdata,
   output logic [DW-1:0]     gpo,
   output logic [DW-1:0]     lcdd,
   output logic [LCDC_W-1:0] lcdc
);
   initial begin
      assert (DW >= STAT_USED) else $error("DW too narrow for status");
      assert (TICK_W <= DW) else $error("TICK_W wider than DW");
      assert (LCDC_W <= DW) else $error("LCDC_W wider than DW");
   end

   port_e       pidx;
   logic        wr_hit;
   logic        rd_kb;
   logic        kb_rdy;
   logic [DW-1:0] kb_hold;
   logic [DW-1:0] stat;

   assign pidx   = port_e'(port);
   assign wr_hit = sel & wr & ce;
   assign rd_kb  = sel & rd & ce & (pidx == PORT_KBD);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gpo  <= '0;
         lcdd <= '0;
         lcdc <= '0;
      end else if (wr_hit) begin
         case (pidx)
            PORT_GPO:  gpo  <= wdata;
            PORT_LCDD: lcdd <= wdata;
            PORT_LCDC: lcdc <= wdata[LCDC_W-1:0];
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         kb_hold <= '0;
         kb_rdy  <= 1'b0;
      end else if (kb_vld) begin
         kb_hold <= kb_byte;
         kb_rdy  <= 1'b1;
      end else if (rd_kb) begin
         kb_rdy  <= 1'b0;
      end
   end

   always_comb begin
      stat           = '0;
      stat[STAT_KB]  = kb_rdy;
      stat[STAT_RX]  = rx_rdy;
      stat[STAT_TX]  = tx_idle;
      stat[STAT_UP]  = sw_up;
      stat[STAT_DN]  = sw_dn;
      stat[STAT_SET] = sw_set;
   end

   always_comb begin
      rdata = '0;
      if (sel && rd) begin
         case (pidx)
            PORT_KBD:  rdata = kb_hold;
            PORT_STAT: rdata = stat;
            PORT_TICK: rdata = DW'(tick);
            PORT_GPO:  rdata = gpo;
            PORT_LCDD: rdata = lcdd;
            PORT_LCDC: rdata = DW'(lcdc);
            default:   rdata = '0;
         endcase
      end
   end

   // R8
   gpo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_hit && pidx == PORT_GPO) |=> $stable(gpo));

   // R8
   gpo_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hit && pidx == PORT_GPO) |=> gpo == $past(wdata));

   // R6
   rdy_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_kb && !kb_vld) |=> !kb_rdy);

   // R3
   rdy_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      kb_vld |=> kb_rdy && kb_hold == $past(kb_byte));
endmodule

// File: rtl/periph_hub.sv
module periph_hub #(
   parameter int CLK_DIV  = 4,
   parameter int TICK_DIV = 16,
   parameter int TICK_W   = 8,
   parameter int DW       = 8,
   parameter int LCDC_W   = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic              sys_ce,
   input  logic              bus_sel,
   input  logic              bus_rd,
   input  logic              bus_wr,
   input  logic [2:0]        bus_port,
   input  logic [DW-1:0]     bus_wdata,
   output logic [DW-1:0]     bus_rdata,
   input  logic              kbd_clk,
   input  logic              kbd_dat,
   input  logic              sio_rx_ready,
   input  logic              sio_tx_idle,
   input  logic              nav_up,
   input  logic              nav_down,
   input  logic              nav_set,
   output logic [DW-1:0]     gp_out,
   output logic [DW-1:0]     lcd_data,
   output logic [LCDC_W-1:0] lcd_ctrl
);
   logic [TICK_W-1:0] tick;
   logic              kb_vld;
   logic [DW-1:0]     kb_byte;

   hub_timebase #(.CLK_DIV(CLK_DIV), .TICK_DIV(TICK_DIV), .TICK_W(TICK_W)) u_tb (
      .clk(clk), .rst_n(rst_n), .ce(sys_ce), .tick(tick)
   );

   hub_ps2rx #(.DW(DW)) u_kb (
      .clk(clk), .rst_n(rst_n), .ps2_clk(kbd_clk), .ps2_dat(kbd_dat),
      .byte_vld(kb_vld), .byte_out(kb_byte)
   );

   hub_portregs #(.DW(DW), .TICK_W(TICK_W), .LCDC_W(LCDC_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .ce(sys_ce),
      .sel(bus_sel), .rd(bus_rd), .wr(bus_wr), .port(bus_port), .wdata(bus_wdata),
      .kb_vld(kb_vld), .kb_byte(kb_byte), .tick(tick),
      .rx_rdy(sio_rx_ready), .tx_idle(sio_tx_idle),
      .sw_up(nav_up), .sw_dn(nav_down), .sw_set(nav_set),
      .rdata(bus_rdata), .gpo(gp_out), .lcdd(lcd_data), .lcdc(lcd_ctrl)
   );
endmodule

// File: tb/periph_hub_bench.sv
module periph_hub_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sys_ce;
   logic       bus_sel = 0, bus_rd = 0, bus_wr = 0;
   logic [2:0] bus_port = '0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic       kbd_clk = 1'b1, kbd_dat = 1'b1;
   logic       sio_rx_ready = 0, sio_tx_idle = 0;
   logic       nav_up = 0, nav_down = 0, nav_set = 0;
   logic [7:0] gp_out, lcd_data;
   logic [2:0] lcd_ctrl;

   int total = 0;
   int bad   = 0;
   int edges = 0;

   always #5 clk = ~clk;

   always @(posedge clk) if (rst_n) edges <= edges + 1;

   periph_hub u_periph_hub (
      .clk(clk), .rst_n(rst_n), .sys_ce(sys_ce),
      .bus_sel(bus_sel), .bus_rd(bus_rd), .bus_wr(bus_wr),
      .bus_port(bus_port), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .kbd_clk(kbd_clk), .kbd_dat(kbd_dat),
      .sio_rx_ready(sio_rx_ready), .sio_tx_idle(sio_tx_idle),
      .nav_up(nav_up), .nav_down(nav_down), .nav_set(nav_set),
      .gp_out(gp_out), .lcd_data(lcd_data), .lcd_ctrl(lcd_ctrl)
   );

   task automatic chk(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   task automatic bus_write(input logic [2:0] p, input logic [7:0] v);
      @(negedge clk);
      bus_sel = 1; bus_wr = 1; bus_port = p; bus_wdata = v;
      repeat (4) @(posedge clk);
      @(negedge clk);
      bus_sel = 0; bus_wr = 0;
   endtask

   task automatic bus_read(input logic [2:0] p, output logic [7:0] v);
      @(negedge clk);
      bus_sel = 1; bus_rd = 1; bus_port = p;
      #1 v = bus_rdata;
      repeat (4) @(posedge clk);
      @(negedge clk);
      bus_sel = 0; bus_rd = 0;
   endtask

   task automatic kb_bit(input logic b);
      @(negedge clk);
      kbd_dat = b;
      repeat (8) @(negedge clk);
      kbd_clk = 1'b0;
      repeat (8) @(negedge clk);
      kbd_clk = 1'b1;
   endtask

   task automatic kb_frame(input logic [7:0] b, input logic bad_par, input logic bad_stop);
      logic par;
      par = ~(^b) ^ bad_par;
      kb_bit(1'b0);
      for (int i = 0; i < 8; i++) kb_bit(b[i]);
      kb_bit(par);
      kb_bit(~bad_stop);
      kbd_dat = 1'b1;
      repeat (12) @(negedge clk);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [7:0] v;
      logic [7:0] kb_vals [4];
      kb_vals[0] = 8'hA5; kb_vals[1] = 8'h00; kb_vals[2] = 8'hFF; kb_vals[3] = 8'h3C;

      repeat (3) @(posedge clk);
      // R11 reset state, read combinationally while reset is held
      @(negedge clk);
      bus_sel = 1; bus_rd = 1;
      for (int p = 0; p < 8; p++) begin
         bus_port = 3'(p);
         #1 chk("R11 read", int'(bus_rdata), 0);
      end
      bus_sel = 0; bus_rd = 0;
      chk("R11 gp_out", int'(gp_out), 0);
      chk("R11 lcd_data", int'(lcd_data), 0);
      chk("R11 lcd_ctrl", int'(lcd_ctrl), 0);

      @(negedge clk);
      rst_n = 1'b1;

      // R1 and R2: enable pattern and tick value through a full wrap
      bus_sel = 1; bus_rd = 1; bus_port = 3'd2;
      for (int i = 0; i < 17000; i++) begin
         @(negedge clk);
         #1;
         chk("R1 sys_ce", int'(sys_ce), int'((edges % 4) == 3));
         chk("R2 tick", int'(bus_rdata), (edges / 64) % 256);
      end
      bus_sel = 0; bus_rd = 0;

      // R10 read data is zero without both strobes
      @(negedge clk);
      bus_sel = 1; bus_rd = 0; bus_port = 3'd2;
      #1 chk("R10 no rd", int'(bus_rdata), 0);
      bus_sel = 0; bus_rd = 1;
      #1 chk("R10 no sel", int'(bus_rdata), 0);
      bus_rd = 0;

      // R7 status layout over every flag and switch combination
      for (int c = 0; c < 32; c++) begin
         @(negedge clk);
         {nav_set, nav_down, nav_up, sio_tx_idle, sio_rx_ready} = 5'(c);
         bus_read(3'd1, v);
         chk("R7 status", int'(v), c << 1);
      end
      {nav_set, nav_down, nav_up, sio_tx_idle, sio_rx_ready} = 5'd0;

      // R3 and R6: good frames
      for (int k = 0; k < 4; k++) begin
         kb_frame(kb_vals[k], 1'b0, 1'b0);
         bus_read(3'd1, v);
         chk("R3 ready", int'(v[0]), 1);
         bus_read(3'd0, v);
         chk("R3 byte", int'(v), int'(kb_vals[k]));
         bus_read(3'd1, v);
         chk("R6 cleared", int'(v[0]), 0);
      end

      // R5 overwrite without a read
      kb_frame(8'h11, 1'b0, 1'b0);
      kb_frame(8'h22, 1'b0, 1'b0);
      bus_read(3'd0, v);
      chk("R5 overwrite", int'(v), 8'h22);

      // R4 bad parity, then bad stop
      kb_frame(8'h77, 1'b1, 1'b0);
      bus_read(3'd1, v);
      chk("R4 parity ready", int'(v[0]), 0);
      bus_read(3'd0, v);
      chk("R4 parity byte", int'(v), 8'h22);
      kb_frame(8'h55, 1'b0, 1'b1);
      bus_read(3'd1, v);
      chk("R4 stop ready", int'(v[0]), 0);
      bus_read(3'd0, v);
      chk("R4 stop byte", int'(v), 8'h22);

      // R8 general output sweep
      for (int d = 0; d < 256; d++) begin
         bus_write(3'd3, 8'(d));
         chk("R8 gp_out", int'(gp_out), d);
         bus_read(3'd3, v);
         chk("R8 readback", int'(v), d);
      end

      // R9 LCD sweeps
      for (int d = 0; d < 256; d += 7) begin
         bus_write(3'd4, 8'(d));
         bus_write(3'd5, 8'(255 - d));
         chk("R9 lcd_data", int'(lcd_data), d);
         chk("R9 lcd_ctrl", int'(lcd_ctrl), (255 - d) & 7);
         chk("R9 gp_out kept", int'(gp_out), 255);
         bus_read(3'd4, v);
         chk("R9 lcd_data read", int'(v), d);
         bus_read(3'd5, v);
         chk("R9 lcd_ctrl read", int'(v), (255 - d) & 7);
      end

      // R10 spare ports
      bus_write(3'd3, 8'h5A);
      bus_write(3'd4, 8'hC3);
      bus_write(3'd5, 8'h02);
      for (int p = 6; p < 8; p++) begin
         bus_write(3'(p), 8'hFF);
         chk("R10 gp_out", int'(gp_out), 8'h5A);
         chk("R10 lcd_data", int'(lcd_data), 8'hC3);
         chk("R10 lcd_ctrl", int'(lcd_ctrl), 2);
         bus_read(3'(p), v);
         chk("R10 spare read", int'(v), 0);
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule